// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator with APB Register Port

This block gathers a configurable number of level-sensitive interrupt lines (2 to 64, fixed at build time) and merges them into a single request line for a parent interrupt controller. Each line passes through its own enable gate and its own suppress (mask) gate. Software programs these gates and reads the resulting per-line status through an APB slave port. The register space is split into a lower 32-bit half for lines 0 to 31 and an upper half for lines 32 to 63.

Register bits exist only for lines that are built. All other bits ignore writes and read as zero. Driver software can therefore find how many lines are present by writing all ones to the enable registers and reading them back. The status is purely level-based: a bit stays set while its line stays high and drops when the line drops, so there is no acknowledge or clear register.

A small phase state machine follows the APB transfer through three states. `PH_IDLE` moves to `PH_SETUP` on a setup cycle (select high, enable low). `PH_SETUP` moves to `PH_ACCESS` on the access cycle, stays in `PH_SETUP` on a repeated setup cycle, and otherwise returns to `PH_IDLE`. `PH_ACCESS` moves to `PH_SETUP` on a back-to-back setup cycle and otherwise goes to `PH_IDLE`. A write commits only on an access cycle that follows `PH_SETUP`. Read data is captured at the end of the setup cycle.

Top module: `apb_lvl_intc`

## Requirements
- R1: After reset, every enable and mask bit is 0, irq_out is 0, and all six registers read as 0.
- R2: Enable lives at offset 0x00 (lines 0-31, line n at bit n) and 0x04 (line n at bit n-32). Only bits of built lines store write data. Other bits read 0, so with 40 lines an all-ones write reads back 0xFFFFFFFF low and 0x000000FF high.
- R3: Mask lives at offsets 0x08 (low) and 0x0C (high) with the same bit layout and the same rule for absent bits. A mask bit of 1 suppresses its line and 0 passes it.
- R4: Final status at 0x30 (low) and 0x34 (high) reads, for each line n, the two-flop-synchronised input n AND enable n AND NOT mask n, at the same bit positions as R2.
- R5: irq_out is the registered OR of all final-status bits. A change on an input of an enabled, unmasked line reaches irq_out on the third rising clock edge after it is applied.
- R6: Reads of any other offset (including non-word-aligned ones) return 0. Writes to other offsets or to the status offsets change no register.
- R7: pready is always 1 and pslverr is always 0.
- R8: A status bit stays set for as long as its input stays high, with no clearing action, and drops once the input falls.
- R9: Enable and mask change only on the access cycle of a write transfer. An enable write and a synchronised input change that land on the same edge both take effect on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase of the transfer |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access cycle |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq_in | input | NUM_SRC | Level-sensitive interrupt lines |
| irq_out | output | 1 | Combined, registered request line |

## Verification
Two functions can fall on the same clock edge: a register write that opens an enable gate, and the synchronised arrival of a raised input line. The bench provokes this by raising a line on the setup half of an enable write, so that the line leaves the second synchroniser flop on the very edge where the write commits. It judges the result from irq_out, which must still be low after that edge and high one edge later, and from a status read that must show the line. Full sweeps of single lines over both halves, with masking and with pseudo-random combinations, check every status bit against values worked out in the bench.

// File: rtl/apb_intc_pkg.sv
package apb_intc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } apb_phase_e;

    typedef enum logic [2:0] {
        SEL_NONE   = 3'd0,
        SEL_EN_LO  = 3'd1,
        SEL_EN_HI  = 3'd2,
        SEL_MSK_LO = 3'd3,
        SEL_MSK_HI = 3'd4,
        SEL_ST_LO  = 3'd5,
        SEL_ST_HI  = 3'd6
    } reg_sel_e;

    localparam int OFS_EN_LO  = 'h00;
    localparam int OFS_EN_HI  = 'h04;
    localparam int OFS_MSK_LO = 'h08;
    localparam int OFS_MSK_HI = 'h0C;
    localparam int OFS_ST_LO  = 'h30;
    localparam int OFS_ST_HI  = 'h34;

    localparam int HALF_W = 32;
    localparam int MAX_SRC = 64;

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg[0] <= '0;
        end else begin
            stg[0] <= d_in;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg[s] <= '0;
            end else begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign d_out = stg[STAGES-1];
endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
    import apb_intc_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_lo,
    input  logic               wr_en_hi,
    input  logic               wr_msk_lo,
    input  logic               wr_msk_hi,
    input  logic [31:0]        wdata,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] msk_q
);
    // Write data bits for absent lines have no storage; fold them into a sink.
    logic unused_wdata_par;
    assign unused_wdata_par = ^wdata;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        localparam int HALF = i / HALF_W;
        localparam int POS  = i % HALF_W;

        logic hit_en;
        logic hit_msk;
        logic en_b;
        logic msk_b;

        assign hit_en  = (HALF == 0) ? wr_en_lo  : wr_en_hi;
        assign hit_msk = (HALF == 0) ? wr_msk_lo : wr_msk_hi;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_b <= 1'b0;
            end else if (hit_en) begin
                en_b <= wdata[POS];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                msk_b <= 1'b0;
            end else if (hit_msk) begin
                msk_b <= wdata[POS];
            end
        end

        assign en_q[i]  = en_b;
        assign msk_q[i] = msk_b;
    end
endmodule

// File: rtl/intc_status.sv
module intc_status #(
    parameter int NUM_SRC = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_sync,
    input  logic [NUM_SRC-1:0] en_q,
    input  logic [NUM_SRC-1:0] msk_q,
    output logic [NUM_SRC-1:0] fstat,
    output logic               irq_q
);
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            fstat[i] = src_sync[i] & en_q[i] & ~msk_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |fstat;
        end
    end
endmodule

// File: rtl/apb_lvl_intc.sv
module apb_lvl_intc
    import apb_intc_pkg::*;
#(
    parameter int NUM_SRC = 40,
    parameter int ADDR_W  = 8
) (
    input  logic               pclk,
    input  logic               presetn,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    output logic               pready,
    output logic               pslverr,
    input  logic [NUM_SRC-1:0] irq_in,
    output logic               irq_out
);
    localparam int PAD_W = MAX_SRC - NUM_SRC;

    if (NUM_SRC < 2 || NUM_SRC > MAX_SRC) begin : g_bad_cfg
        $error("apb_lvl_intc: NUM_SRC out of range");
    end
    if (ADDR_W < 6) begin : g_bad_addr
        $error("apb_lvl_intc: ADDR_W too small for the register map");
    end

    // ---------------- transfer phase state machine ----------------
    apb_phase_e ph_q;
    apb_phase_e ph_d;
    logic       wr_stb;
    logic       rd_cap;

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            ph_q <= PH_IDLE;
        end else begin
            ph_q <= ph_d;
        end
    end

    always_comb begin
        ph_d = PH_IDLE;
        unique case (ph_q)
            PH_IDLE: begin
                ph_d = (psel && !penable) ? PH_SETUP : PH_IDLE;
            end
            PH_SETUP: begin
                if (psel && penable) begin
                    ph_d = PH_ACCESS;
                end else if (psel) begin
                    ph_d = PH_SETUP;
                end else begin
                    ph_d = PH_IDLE;
                end
            end
            PH_ACCESS: begin
                ph_d = (psel && !penable) ? PH_SETUP : PH_IDLE;
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_comb begin
        wr_stb = 1'b0;
        rd_cap = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                rd_cap = psel && !penable && !pwrite;
            end
            PH_SETUP: begin
                wr_stb = psel && penable && pwrite;
                rd_cap = psel && !penable && !pwrite;
            end
            PH_ACCESS: begin
                rd_cap = psel && !penable && !pwrite;
            end
            default: begin
                wr_stb = 1'b0;
                rd_cap = 1'b0;
            end
        endcase
    end

    // ---------------- address decode ----------------
    reg_sel_e sel_d;

    always_comb begin
        sel_d = SEL_NONE;
        if (paddr == ADDR_W'(OFS_EN_LO)) begin
            sel_d = SEL_EN_LO;
        end else if (paddr == ADDR_W'(OFS_EN_HI)) begin
            sel_d = SEL_EN_HI;
        end else if (paddr == ADDR_W'(OFS_MSK_LO)) begin
            sel_d = SEL_MSK_LO;
        end else if (paddr == ADDR_W'(OFS_MSK_HI)) begin
            sel_d = SEL_MSK_HI;
        end else if (paddr == ADDR_W'(OFS_ST_LO)) begin
            sel_d = SEL_ST_LO;
        end else if (paddr == ADDR_W'(OFS_ST_HI)) begin
            sel_d = SEL_ST_HI;
        end
    end

    logic wr_en_lo;
    logic wr_en_hi;
    logic wr_msk_lo;
    logic wr_msk_hi;

    assign wr_en_lo  = wr_stb && (sel_d == SEL_EN_LO);
    assign wr_en_hi  = wr_stb && (sel_d == SEL_EN_HI);
    assign wr_msk_lo = wr_stb && (sel_d == SEL_MSK_LO);
    assign wr_msk_hi = wr_stb && (sel_d == SEL_MSK_HI);

    // ---------------- datapath ----------------
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] msk_q;
    logic [NUM_SRC-1:0] src_sync;
    logic [NUM_SRC-1:0] fstat;
    logic               irq_q;

    intc_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (2)
    ) u_sync (
        .clk   (pclk),
        .rst_n (presetn),
        .d_in  (irq_in),
        .d_out (src_sync)
    );

    intc_regfile #(
        .NUM_SRC (NUM_SRC)
    ) u_regs (
        .clk       (pclk),
        .rst_n     (presetn),
        .wr_en_lo  (wr_en_lo),
        .wr_en_hi  (wr_en_hi),
        .wr_msk_lo (wr_msk_lo),
        .wr_msk_hi (wr_msk_hi),
        .wdata     (pwdata),
        .en_q      (en_q),
        .msk_q     (msk_q)
    );

    intc_status #(
        .NUM_SRC (NUM_SRC)
    ) u_stat (
        .clk      (pclk),
        .rst_n    (presetn),
        .src_sync (src_sync),
        .en_q     (en_q),
        .msk_q    (msk_q),
        .fstat    (fstat),
        .irq_q    (irq_q)
    );

    // ---------------- read path ----------------
    logic [MAX_SRC-1:0] en_w;
    logic [MAX_SRC-1:0] msk_w;
    logic [MAX_SRC-1:0] st_w;

    if (PAD_W > 0) begin : g_pad
        assign en_w  = {{PAD_W{1'b0}}, en_q};
        assign msk_w = {{PAD_W{1'b0}}, msk_q};
        assign st_w  = {{PAD_W{1'b0}}, fstat};
    end else begin : g_full
        assign en_w  = en_q;
        assign msk_w = msk_q;
        assign st_w  = fstat;
    end

    logic [31:0] rd_mux;
    logic [31:0] prdata_q;

    always_comb begin
        rd_mux = '0;
        unique case (sel_d)
            SEL_EN_LO:  rd_mux = en_w[31:0];
            SEL_EN_HI:  rd_mux = en_w[63:32];
            SEL_MSK_LO: rd_mux = msk_w[31:0];
            SEL_MSK_HI: rd_mux = msk_w[63:32];
            SEL_ST_LO:  rd_mux = st_w[31:0];
            SEL_ST_HI:  rd_mux = st_w[63:32];
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            prdata_q <= '0;
        end else if (rd_cap) begin
            prdata_q <= rd_mux;
        end
    end

    assign prdata  = prdata_q;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign irq_out = irq_q;
endmodule

// File: rtl/apb_lvl_intc_chk.sv
module apb_lvl_intc_chk #(
    parameter int NUM_SRC = 40
) (
    input logic               clk,
    input logic               rst_n,
    input logic               psel,
    input logic               penable,
    input logic               pwrite,
    input logic               pready,
    input logic               pslverr,
    input logic [NUM_SRC-1:0] irq_in,
    input logic               irq_out,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] msk_q
);
    // R7
    a_r7_fixed_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        pready && !pslverr);

    // R5: a request needs a raised line three edges back
    a_r5_irq_has_line: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (|$past(irq_in, 3)));

    // R5: a request needs some enabled, unmasked line one edge back
    a_r5_irq_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (|$past(en_q & ~msk_q)));

    // R9: enable moves only after an access-phase write
    a_r9_en_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_q) |-> $past(psel && penable && pwrite));

    // R9: mask moves only after an access-phase write
    a_r9_msk_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(msk_q) |-> $past(psel && penable && pwrite));
endmodule

bind apb_lvl_intc apb_lvl_intc_chk #(
    .NUM_SRC (NUM_SRC)
) u_chk (
    .clk     (pclk),
    .rst_n   (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .pready  (pready),
    .pslverr (pslverr),
    .irq_in  (irq_in),
    .irq_out (irq_out),
    .en_q    (en_q),
    .msk_q   (msk_q)
);

// File: tb/apb_lvl_intc_bench.sv
module apb_lvl_intc_bench;
    localparam int N  = 40;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0;
    logic          penable = 1'b0;
    logic          pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic          pready;
    logic          pslverr;
    logic [N-1:0]  irq_in = '0;
    logic          irq_out;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [63:0] cfg_m;
    logic [63:0] m_en;
    logic [63:0] m_mk;
    logic [31:0] seed;

    always #4 clk = ~clk;

    apb_lvl_intc #(.NUM_SRC(N), .ADDR_W(AW)) u_apb_lvl_intc (
        .pclk    (clk),
        .presetn (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .pready  (pready),
        .pslverr (pslverr),
        .irq_in  (irq_in),
        .irq_out (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        d = prdata;
        if (!(pready === 1'b1 && pslverr === 1'b0)) begin
            check("R7", {30'd0, pready, pslverr}, 32'h2);
        end
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
        logic [31:0] d;
        apb_rd(a, d);
        check(req, d, exp);
    endtask

    function automatic logic [63:0] exp_stat(input logic [63:0] in64);
        return in64 & m_en & ~m_mk & cfg_m;
    endfunction

    task automatic set_in(input logic [63:0] v);
        @(negedge clk);
        irq_in = v[N-1:0];
        repeat (3) @(negedge clk);
    endtask

    task automatic stat_chk(input string req, input logic [63:0] in64);
        logic [63:0] e;
        e = exp_stat(in64);
        check(req, {31'd0, irq_out}, {31'd0, |e});
        rd_chk(req, 8'h30, e[31:0]);
        rd_chk(req, 8'h34, e[63:32]);
    endtask

    task automatic wr_all(input logic [63:0] en, input logic [63:0] mk);
        apb_wr(8'h00, en[31:0]);
        apb_wr(8'h04, en[63:32]);
        apb_wr(8'h08, mk[31:0]);
        apb_wr(8'h0C, mk[63:32]);
        m_en = en & cfg_m;
        m_mk = mk & cfg_m;
    endtask

    function automatic logic [31:0] lcg(input logic [31:0] s);
        return s * 32'd1103515245 + 32'd12345;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        cfg_m = (64'd1 << N) - 64'd1;
        m_en  = '0;
        m_mk  = '0;
        seed  = 32'h1234_5678;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1", {31'd0, irq_out}, 32'd0);
        check("R1", prdata, 32'd0);
        rd_chk("R1", 8'h00, 32'd0);
        rd_chk("R1", 8'h04, 32'd0);
        rd_chk("R1", 8'h08, 32'd0);
        rd_chk("R1", 8'h0C, 32'd0);
        rd_chk("R1", 8'h30, 32'd0);
        rd_chk("R1", 8'h34, 32'd0);

        // R7: handshake outputs
        check("R7", {30'd0, pready, pslverr}, 32'h2);

        // R2: enable, only built bits
        apb_wr(8'h00, 32'hFFFF_FFFF);
        apb_wr(8'h04, 32'hFFFF_FFFF);
        rd_chk("R2", 8'h00, 32'hFFFF_FFFF);
        rd_chk("R2", 8'h04, 32'h0000_00FF);
        apb_wr(8'h00, 32'hA5A5_5A5A);
        apb_wr(8'h04, 32'h3C3C_3C3C);
        rd_chk("R2", 8'h00, 32'hA5A5_5A5A);
        rd_chk("R2", 8'h04, 32'h0000_003C);

        // R3: mask, only built bits
        apb_wr(8'h08, 32'hFFFF_FFFF);
        apb_wr(8'h0C, 32'hFFFF_FFFF);
        rd_chk("R3", 8'h08, 32'hFFFF_FFFF);
        rd_chk("R3", 8'h0C, 32'h0000_00FF);
        apb_wr(8'h08, 32'h0F0F_F0F0);
        apb_wr(8'h0C, 32'h1234_56C3);
        rd_chk("R3", 8'h08, 32'h0F0F_F0F0);
        rd_chk("R3", 8'h0C, 32'h0000_00C3);

        // R4/R5: walk a single line over both halves, gates open
        wr_all(64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
        for (int i = 0; i < N; i++) begin
            set_in(64'd1 << i);
            stat_chk("R4", 64'd1 << i);
        end

        // R3: walk a single line with only that line masked
        for (int i = 0; i < N; i++) begin
            apb_wr(i < 32 ? 8'h08 : 8'h0C, 32'd1 << (i % 32));
            apb_wr(i < 32 ? 8'h0C : 8'h08, 32'd0);
            m_mk = 64'd1 << i;
            set_in(cfg_m);
            stat_chk("R3", cfg_m);
        end

        // R4: pseudo-random gate and line combinations
        for (int k = 0; k < 24; k++) begin
            logic [63:0] en;
            logic [63:0] mk;
            logic [63:0] iv;
            seed = lcg(seed); en[31:0]  = seed;
            seed = lcg(seed); en[63:32] = seed;
            seed = lcg(seed); mk[31:0]  = seed;
            seed = lcg(seed); mk[63:32] = seed;
            seed = lcg(seed); iv[31:0]  = seed;
            seed = lcg(seed); iv[63:32] = seed;
            wr_all(en, mk);
            set_in(iv);
            stat_chk("R4", iv);
        end

        // R5: latency of a rising line is three edges
        wr_all(64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
        set_in(64'd0);
        @(negedge clk);
        irq_in = 40'd1 << 37;
        repeat (2) @(negedge clk);
        check("R5", {31'd0, irq_out}, 32'd0);
        @(negedge clk);
        check("R5", {31'd0, irq_out}, 32'd1);

        // R8: level hold without clearing, then drop
        repeat (10) @(negedge clk);
        check("R8", {31'd0, irq_out}, 32'd1);
        rd_chk("R8", 8'h34, 32'h0000_0020);
        rd_chk("R8", 8'h34, 32'h0000_0020);
        set_in(64'd0);
        check("R8", {31'd0, irq_out}, 32'd0);
        rd_chk("R8", 8'h34, 32'd0);

        // R6: unmapped reads and ignored writes
        wr_all(64'h0000_00AB_1234_5678, 64'h0000_0011_0000_0008);
        set_in(64'h0000_00FF_FFFF_FFFF);
        apb_wr(8'h10, 32'hFFFF_FFFF);
        apb_wr(8'h30, 32'hFFFF_FFFF);
        apb_wr(8'h34, 32'hFFFF_FFFF);
        apb_wr(8'h01, 32'hFFFF_FFFF);
        apb_wr(8'h40, 32'd0);
        rd_chk("R6", 8'h00, 32'h1234_5678);
        rd_chk("R6", 8'h04, 32'h0000_00AB);
        rd_chk("R6", 8'h08, 32'h0000_0008);
        rd_chk("R6", 8'h0C, 32'h0000_0011);
        stat_chk("R6", 64'h0000_00FF_FFFF_FFFF);
        rd_chk("R6", 8'h10, 32'd0);
        rd_chk("R6", 8'h2C, 32'd0);
        rd_chk("R6", 8'h38, 32'd0);
        rd_chk("R6", 8'h01, 32'd0);
        rd_chk("R6", 8'hFC, 32'd0);

        // R9: an idle select without penable writes nothing
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = 8'h00; pwdata = 32'd0;
        @(negedge clk);
        psel = 1'b0; pwrite = 1'b0;
        rd_chk("R9", 8'h00, 32'h1234_5678);

        // R9: enable write and synchronised line arrive on the same edge
        wr_all(64'd0, 64'd0);
        set_in(64'd0);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 8'h00; pwdata = 32'h0000_0004;
        irq_in = 40'd4;
        @(negedge clk);
        penable = 1'b1;
        check("R9", {31'd0, irq_out}, 32'd0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        check("R9", {31'd0, irq_out}, 32'd0);
        @(negedge clk);
        check("R9", {31'd0, irq_out}, 32'd1);
        rd_chk("R9", 8'h30, 32'h0000_0004);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule